// File: doc/BRIEF.md
# Noise Shift-Register Generator

This block is the noise voice of a programmable tone generator. A 16-bit shift register moves one place toward bit 0 on every noise step, and its lowest bit is the one-bit noise output. The steps come from a down-counter that runs on a tick enable. A 2-bit rate field sets the counter's reload value: one of three fixed powers of two, or a value taken from the period of tone voice 2. A mode input selects white noise, where two taps of the register are combined to make the new top bit, or periodic noise, where only one tap is used and the register acts as a 15-stage ring.

Two build parameters set the variant. `XNOR_FB` changes the white-noise feedback from XOR to XNOR. `INVERT_OUT` negates the output bit. A re-seed strobe loads the register with only its top bit set. The strobe is driven by the surrounding register logic, which decides when a mode change or a control write calls for it. Attenuation and mixing belong to the parent block.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While `rst_ni` is low, the shift register holds 0x8000 (only bit 15 set), the step counter holds 31 and the stored rate is 0. `noise_o` then shows bit 0 of the register, which is 0, passed through the optional inversion.
- R2: When `reseed_i` is high at a clock edge, the register becomes 0x8000 after that edge. This takes priority over a noise step in the same cycle.
- R3: On a noise step the register shifts right by one and the new bit 15 is the feedback bit. With no step and no re-seed, the register holds its value. `noise_o` follows register bit 0.
- R4: With `XNOR_FB`=0 and `white_i`=1, the feedback bit is bit 1 XOR bit 5.
- R5: With `XNOR_FB`=1 and `white_i`=1, the feedback bit is the inverse of (bit 1 XOR bit 5).
- R6: With `white_i`=0, the feedback bit is bit 1 in both variants. A register seeded with 0x8000 therefore repeats with a period of 15 steps.
- R7: With `INVERT_OUT`=1, `noise_o` is the inverse of register bit 0.
- R8: Rate values 0, 1 and 2 give one noise step every 32, 64 and 128 ticks. The counter moves only in cycles where `tick_i` is high, and a step happens on a tick that finds the counter at zero.
- R9: Rate value 3 gives one step every 2×`tone2_period_i` ticks. A tone-2 period of 0 gives a step on every tick.
- R10: In a cycle where `rate_i` differs from the stored rate, the counter reloads for the new rate and no step happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable for the step counter |
| rate_i | input | 2 | Noise rate select: 0..2 fixed, 3 uses tone 2 |
| white_i | input | 1 | 1 selects white noise, 0 selects periodic |
| tone2_period_i | input | TONE_W | Period of tone voice 2 |
| reseed_i | input | 1 | Loads the register with 0x8000 |
| noise_o | output | 1 | Noise output bit |

## Verification
The embedded properties assume that every input is at a known 0 or 1 at each clock edge. They also assume that `rate_i` is compared against the stored rate, so a change of rate counts as a restart and never as a countdown. The stimulus changes inputs only on falling clock edges and never drives X. It holds `tone2_period_i` steady for a whole phase and changes it only alongside a rate change or a long hold. The bench covers both feedback variants by running an XNOR, inverted-output instance alongside the default one under the same stimulus.

// File: rtl/noise_gen_pkg.sv
package noise_gen_pkg;

  typedef enum logic [1:0] {
    NR_DIV0  = 2'd0,
    NR_DIV1  = 2'd1,
    NR_DIV2  = 2'd2,
    NR_TONE2 = 2'd3
  } noise_rate_e;

  // Lower-tap term of the feedback; the xnor variant asserts it on a cleared bit.
  function automatic logic lo_tap_term(input logic bit_v, input logic xnor_v);
    return xnor_v ? ~bit_v : bit_v;
  endfunction

endpackage

// File: rtl/noise_rate_timer.sv
module noise_rate_timer
  import noise_gen_pkg::*;
#(
  parameter int TONE_W    = 10,
  parameter int BASE_LOG2 = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        rate_i,
  input  logic [TONE_W-1:0] tone_period_i,
  output logic              noise_clk_o
);

  localparam int CNT_W = (TONE_W + 1 > BASE_LOG2 + 3) ? TONE_W + 1 : BASE_LOG2 + 3;
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'((1 << BASE_LOG2) - 1);

  logic [CNT_W-1:0] cnt_q, period, load_val;
  logic [1:0]       rate_q;
  logic             rate_chg;

  always_comb begin
    if (rate_i == 2'(NR_TONE2)) period = CNT_W'({tone_period_i, 1'b0});
    else                        period = CNT_W'(1) << (BASE_LOG2 + int'(rate_i));
    load_val = (period == '0) ? '0 : period - CNT_W'(1);
  end

  assign rate_chg    = (rate_i != rate_q);
  assign noise_clk_o = tick_i && !rate_chg && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RST_LOAD;
      rate_q <= 2'(NR_DIV0);
    end else begin
      rate_q <= rate_i;
      if (rate_chg || noise_clk_o) cnt_q <= load_val;
      else if (tick_i)             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_countdown_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !rate_chg && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !rate_chg) |=> $stable(cnt_q));

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
  import noise_gen_pkg::*;
#(
  parameter int LFSR_W  = 16,
  parameter int TAP_HI  = 1,
  parameter int TAP_LO  = 5,
  parameter bit XNOR_FB = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              reseed_i,
  input  logic              white_i,
  output logic [LFSR_W-1:0] state_o
);

  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = state_q[TAP_HI] ^ (lo_tap_term(state_q[TAP_LO], XNOR_FB) & white_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= SEED;
    else if (reseed_i) state_q <= SEED;
    else if (step_i)   state_q <= {fb, state_q[LFSR_W-1:1]};
  end

  assign state_o = state_q;

  assert_seed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseed_i |=> (state_q == SEED));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !reseed_i) |=> $stable(state_q));

  assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !reseed_i) |=> (state_q[LFSR_W-2:0] == $past(state_q[LFSR_W-1:1])));

  assert_periodic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !reseed_i && !white_i) |=> (state_q[LFSR_W-1] == $past(state_q[TAP_HI])));

  generate
    if (XNOR_FB) begin : g_xnor_chk
      assert_white_xnor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !reseed_i && white_i) |=>
        (state_q[LFSR_W-1] == !($past(state_q[TAP_HI]) ^ $past(state_q[TAP_LO]))));
    end else begin : g_xor_chk
      assert_white_xor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !reseed_i && white_i) |=>
        (state_q[LFSR_W-1] == ($past(state_q[TAP_HI]) ^ $past(state_q[TAP_LO]))));
    end
  endgenerate

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_gen_pkg::*;
#(
  parameter int LFSR_W     = 16,
  parameter int TONE_W     = 10,
  parameter int BASE_LOG2  = 5,
  parameter int TAP_HI     = 1,
  parameter int TAP_LO     = 5,
  parameter bit XNOR_FB    = 1'b0,
  parameter bit INVERT_OUT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        rate_i,
  input  logic              white_i,
  input  logic [TONE_W-1:0] tone2_period_i,
  input  logic              reseed_i,
  output logic              noise_o
);

  logic              noise_clk;
  logic [LFSR_W-1:0] lfsr_state;

  noise_rate_timer #(
    .TONE_W   (TONE_W),
    .BASE_LOG2(BASE_LOG2)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .rate_i       (rate_i),
    .tone_period_i(tone2_period_i),
    .noise_clk_o  (noise_clk)
  );

  noise_lfsr_core #(
    .LFSR_W (LFSR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO),
    .XNOR_FB(XNOR_FB)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (noise_clk),
    .reseed_i(reseed_i),
    .white_i (white_i),
    .state_o (lfsr_state)
  );

  generate
    if (INVERT_OUT) begin : g_inv
      assign noise_o = ~lfsr_state[0];
    end else begin : g_plain
      assign noise_o = lfsr_state[0];
    end
  endgenerate

  assert_no_step_on_rate_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !reseed_i && (rate_i != $past(rate_i))) |=> $stable(lfsr_state));

endmodule

// File: tb/tb_noise_lfsr_gen.sv
module tb_noise_lfsr_gen;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] rate_i = 2'd0;
  logic       white_i = 1'b0;
  logic [9:0] tone2_period_i = 10'd0;
  logic       reseed_i = 1'b0;
  logic       noise_std, noise_alt;

  int total = 0;
  int bad = 0;
  bit stim_done = 1'b0;

  always #5 clk_i = ~clk_i;

  noise_lfsr_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rate_i(rate_i),
    .white_i(white_i), .tone2_period_i(tone2_period_i), .reseed_i(reseed_i),
    .noise_o(noise_std)
  );

  noise_lfsr_gen #(.XNOR_FB(1'b1), .INVERT_OUT(1'b1)) dut_alt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rate_i(rate_i),
    .white_i(white_i), .tone2_period_i(tone2_period_i), .reseed_i(reseed_i),
    .noise_o(noise_alt)
  );

  typedef struct {
    logic  e_std;
    logic  e_alt;
    string tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] m_std, m_alt;
  int          m_cnt;
  logic [1:0]  m_rate;

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] shift_model(input logic [15:0] s, input logic wht, input bit xn);
    logic f;
    if (!wht)    f = s[1];
    else if (xn) f = ~(s[1] ^ s[5]);
    else         f = s[1] ^ s[5];
    return {f, s[15:1]};
  endfunction

  task automatic drive(input logic tk, input logic [1:0] rt, input logic wh,
                       input logic [9:0] tp, input logic rs, input string tag);
    int per, ld;
    bit chg, nclk;
    exp_t it;
    @(negedge clk_i);
    tick_i = tk; rate_i = rt; white_i = wh; tone2_period_i = tp; reseed_i = rs;
    per  = (rt == 2'd3) ? 2 * int'(tp) : (32 << rt);
    ld   = (per == 0) ? 0 : per - 1;
    chg  = (rt != m_rate);
    nclk = tk && !chg && (m_cnt == 0);
    if (chg || nclk) m_cnt = ld;
    else if (tk)     m_cnt = m_cnt - 1;
    m_rate = rt;
    if (rs) begin
      m_std = 16'h8000; m_alt = 16'h8000;
    end else if (nclk) begin
      m_std = shift_model(m_std, wh, 1'b0);
      m_alt = shift_model(m_alt, wh, 1'b1);
    end
    it.e_std = m_std[0];
    it.e_alt = ~m_alt[0];
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: pops one expected item per cycle, sampled after the edge settles.
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check(noise_std, it.e_std, {it.tag, " xor/plain"});
        check(noise_alt, it.e_alt, {it.tag, " xnor/inverted"});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!stim_done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_std = 16'h8000; m_alt = 16'h8000; m_cnt = 31; m_rate = 2'd0;
    repeat (3) @(negedge clk_i);
    check(noise_std, 1'b0, "R1 reset output, plain");
    check(noise_alt, 1'b1, "R7 reset output, inverted");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // first step needs 32 ticks; output still 0 until then
    for (int i = 0; i < 40; i++) drive(1'b1, 2'd0, 1'b0, 10'd0, 1'b0, "R8 first period rate0");
    for (int i = 0; i < 600; i++) drive(1'b1, 2'd0, 1'b0, 10'd0, 1'b0, "R6 periodic ring");
    for (int i = 0; i < 2000; i++) drive(1'b1, 2'd1, 1'b1, 10'd0, 1'b0, "R4/R5 white rate1");
    for (int i = 0; i < 1500; i++) drive((i % 3) != 0, 2'd2, 1'b1, 10'd0, 1'b0, "R8 gapped ticks rate2");
    for (int i = 0; i < 400; i++) drive(1'b1, 2'd3, 1'b1, 10'd3, 1'b0, "R9 tone2 period 3");
    for (int i = 0; i < 100; i++) drive(1'b0, 2'd3, 1'b1, 10'd3, 1'b0, "R3 hold without ticks");
    for (int i = 0; i < 200; i++) drive(1'b1, 2'd3, 1'b1, 10'd0, 1'b0, "R9 zero tone2 period");
    for (int i = 0; i < 200; i++) drive(1'b1, 2'd3, 1'b1, 10'd0, (i % 7) == 3, "R2 reseed over step");
    for (int i = 0; i < 300; i++) drive(1'b1, 2'd3, 1'b0, 10'd0, (i % 11) == 5, "R2 reseed periodic");
    for (int i = 0; i < 1600; i++)
      drive(1'b1, 2'((i / 20) % 4), (i / 80) % 2 == 0, 10'd5, 1'b0, "R10 rate restarts");
    for (int i = 0; i < 300; i++) drive((i % 2) == 0, 2'd0, 1'b1, 10'd5, 1'b0, "R3 shift and hold");

    repeat (3) @(negedge clk_i);
    stim_done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule